// File: doc/BRIEF.md
# Raster Operation Logic Unit

This block is the 16-bit combining stage of a raster engine. For every destination word fetched during a read-modify-write memory cycle, it evaluates a programmable two-input Boolean function of the destination word D and a source operand S. It then merges that value into D under two write masks. Bit positions that the masks do not enable keep the destination value. The combined word leaves on a registered output with a one-cycle valid strobe.

Software programs the unit through an indexed register write port. This port reaches the function register, both masks, the source register, two colour registers and six cycle-control words. Each memory cycle is tagged with a kind (first-source read, second-source read or destination read-modify-write) and a bank. The cycle-control word for that kind and bank decides which data registers take the fetched word and which take an internal colour value, and whether the cycle produces an output word.

Top module: `rop_logic_unit`

## Requirements
- R1: After reset every internal register is zero, `resValid` is 0 and `resData` is 0.
- R2: Function bits 3:0 define F per bit as funcWord[2*D+S]. For example, code 0000 gives all zeros, 0110 gives D XOR S, 1010 gives S, 1100 gives D and 1111 gives all ones.
- R3: A result bit equals F where both effective mask bits are 1 and equals the destination bit elsewhere. Function bit 4 set inverts mask 1 and function bit 5 set inverts mask 2 before use.
- R4: Function bit 6 clear makes S the inverted source register; bit 6 set makes S the source register as stored.
- R5: Register indices are: 0x04 function (bits 6:0 kept), 0x08 mask 1, 0x09 mask 2, 0x0A source, 0x0E background, 0x0F foreground. A write to 0x08 loads both masks; a write to 0x09 changes only mask 2. All are written on one clock edge.
- R6: Cycle-control words sit at index 0x10 + 4*bank + kind, where kind 0 is first-source read, 1 is second-source read and 2 is destination read-modify-write. Bits 1:0 are the external load code, bits 3:2 the internal load code and bit 4 the output enable.
- R7: An external load code puts `memData` into a register. 00 loads nothing, 01 loads source, 10 loads mask 1 and mask 2, and 11 loads mask 2 only.
- R8: The internal load code uses the same encoding. It loads the foreground register's value on bank 0 cycles and the background register's value on bank 1 cycles.
- R9: A destination cycle whose word has bit 4 set gives `resValid`=1 and the result on `resData` one clock after the cycle. Such a result uses the register values held before that edge, with D=`memData`. Every other cycle leaves `resValid` at 0 and `resData` unchanged.
- R10: When the external and internal codes of one cycle target the same register, the external `memData` value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 5 | Register index |
| regData | input | 16 | Register write data |
| cycValid | input | 1 | A memory cycle's data is present |
| cycKind | input | 2 | 0 first source, 1 second source, 2 destination |
| cycBank | input | 1 | Bank of the cycle |
| memData | input | 16 | Fetched memory word (D on destination cycles) |
| resData | output | 16 | Combined result word |
| resValid | output | 1 | Result strobe, one cycle |

## Verification
All state stays hidden until a destination cycle with output enabled. A wrong mask, source or function value therefore shows up only in the first result word after the corrupting event, one clock after that destination cycle. The bench therefore follows each load or write with a destination cycle that uses patterns covering all four D/S combinations. It chooses masks so that every register bit affects some output bit. Wrong steering of loads shows up as a wrong value on that follow-up word, and a wrong output enable shows up as an unexpected strobe in the same clock.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {SEL_KEEP, SEL_HOST, SEL_EXT, SEL_INT} ldSel_e;

  typedef struct packed {
    ldSel_e srcSel;
    ldSel_e m1Sel;
    ldSel_e m2Sel;
    logic   fgWr;
    logic   bgWr;
    logic   outEn;
    logic   intBg;
  } ropStrobe_t;

  localparam logic [1:0] LD_NONE = 2'b00;
  localparam logic [1:0] LD_SRC  = 2'b01;
  localparam logic [1:0] LD_BOTH = 2'b10;
  localparam logic [1:0] LD_M2   = 2'b11;

  localparam logic [4:0] IDX_FUNC = 5'h04;
  localparam logic [4:0] IDX_M1   = 5'h08;
  localparam logic [4:0] IDX_M2   = 5'h09;
  localparam logic [4:0] IDX_SRC  = 5'h0A;
  localparam logic [4:0] IDX_BG   = 5'h0E;
  localparam logic [4:0] IDX_FG   = 5'h0F;
  localparam logic [4:0] IDX_CW   = 5'h10;

  localparam logic [1:0] KIND_DEST = 2'd2;
endpackage

// File: rtl/rop_ctrl.sv
module rop_ctrl
  import rop_pkg::*;
#(
  parameter int FW = 7,
  parameter int CWW = 5,
  parameter int BANKS = 2,
  parameter int KINDS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [4:0]       regIdx,
  input  logic [FW-1:0]    regData,
  input  logic             cycValid,
  input  logic [1:0]       cycKind,
  input  logic             cycBank,
  output logic [FW-1:0]    funcWord,
  output ropStrobe_t       strobe
);
  logic [CWW-1:0] cwReg [BANKS][KINDS];
  logic [CWW-1:0] cwCur;
  logic [1:0]     extCode, intCode;

  always_ff @(posedge clk) begin
    if (!rstN) funcWord <= '0;
    else if (regWrEn && regIdx == IDX_FUNC) funcWord <= regData;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar k = 0; k < KINDS; k++) begin : g_kind
      localparam logic [4:0] MY_IDX = IDX_CW + 5'(4 * b + k);
      always_ff @(posedge clk) begin
        if (!rstN) cwReg[b][k] <= '0;
        else if (regWrEn && regIdx == MY_IDX) cwReg[b][k] <= regData[CWW-1:0];
      end
    end
  end

  always_comb begin
    cwCur = '0;
    for (int b = 0; b < BANKS; b++)
      for (int k = 0; k < KINDS; k++)
        if (cycBank == b[0] && cycKind == k[1:0]) cwCur = cwReg[b][k];
  end

  always_comb begin
    extCode = cycValid ? cwCur[1:0] : LD_NONE;
    intCode = cycValid ? cwCur[3:2] : LD_NONE;

    if (regWrEn && regIdx == IDX_SRC) strobe.srcSel = SEL_HOST;
    else if (extCode == LD_SRC)       strobe.srcSel = SEL_EXT;
    else if (intCode == LD_SRC)       strobe.srcSel = SEL_INT;
    else                              strobe.srcSel = SEL_KEEP;

    if (regWrEn && regIdx == IDX_M1)  strobe.m1Sel = SEL_HOST;
    else if (extCode == LD_BOTH)      strobe.m1Sel = SEL_EXT;
    else if (intCode == LD_BOTH)      strobe.m1Sel = SEL_INT;
    else                              strobe.m1Sel = SEL_KEEP;

    if (regWrEn && (regIdx == IDX_M1 || regIdx == IDX_M2))   strobe.m2Sel = SEL_HOST;
    else if (extCode == LD_BOTH || extCode == LD_M2)         strobe.m2Sel = SEL_EXT;
    else if (intCode == LD_BOTH || intCode == LD_M2)         strobe.m2Sel = SEL_INT;
    else                                                     strobe.m2Sel = SEL_KEEP;

    strobe.fgWr  = regWrEn && regIdx == IDX_FG;
    strobe.bgWr  = regWrEn && regIdx == IDX_BG;
    strobe.outEn = cycValid && cycKind == KIND_DEST && cwCur[4];
    strobe.intBg = cycBank;
  end

  // R6: only the three defined cycle kinds may be presented
  a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> cycKind != 2'd3);

  // R9: output enable can only come from a destination cycle
  a_r9_out_only_dest: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outEn |-> (cycValid && cycKind == KIND_DEST));
endmodule

// File: rtl/rop_datapath.sv
module rop_datapath
  import rop_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  ropStrobe_t    strobe,
  input  logic [FW-1:0] funcWord,
  input  logic [DW-1:0] hostData,
  input  logic [DW-1:0] memData,
  output logic [DW-1:0] resData,
  output logic          resValid
);
  logic [DW-1:0] srcReg, m1Reg, m2Reg, fgReg, bgReg;
  logic [DW-1:0] intData, sEff, effMask, fVal, comb;

  assign intData = strobe.intBg ? bgReg : fgReg;

  function automatic logic [DW-1:0] pick(ldSel_e sel, logic [DW-1:0] cur,
                                         logic [DW-1:0] h, logic [DW-1:0] e,
                                         logic [DW-1:0] i);
    case (sel)
      SEL_HOST: return h;
      SEL_EXT:  return e;
      SEL_INT:  return i;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0; m1Reg <= '0; m2Reg <= '0; fgReg <= '0; bgReg <= '0;
      resData <= '0; resValid <= 1'b0;
    end else begin
      srcReg <= pick(strobe.srcSel, srcReg, hostData, memData, intData);
      m1Reg  <= pick(strobe.m1Sel,  m1Reg,  hostData, memData, intData);
      m2Reg  <= pick(strobe.m2Sel,  m2Reg,  hostData, memData, intData);
      if (strobe.fgWr) fgReg <= hostData;
      if (strobe.bgWr) bgReg <= hostData;
      resValid <= strobe.outEn;
      if (strobe.outEn) resData <= comb;
    end
  end

  assign sEff    = funcWord[6] ? srcReg : ~srcReg;
  assign effMask = (funcWord[4] ? ~m1Reg : m1Reg) & (funcWord[5] ? ~m2Reg : m2Reg);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign fVal[i] = funcWord[{memData[i], sEff[i]}];
    assign comb[i] = effMask[i] ? fVal[i] : memData[i];
  end

  // R3: with no enabled bit, the result equals the destination word
  a_r3_unmasked_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outEn && effMask == '0) |=> resData == $past(memData));

  // R5: a host write to mask 1 leaves both masks equal
  a_r5_mask_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.m1Sel == SEL_HOST) |=> m1Reg == m2Reg);

  // R7: source register holds when nothing selects it
  a_r7_src_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.srcSel == SEL_KEEP) |=> $stable(srcReg));

  // R9: result word holds while no output is produced
  a_r9_res_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |=> $stable(resData));
endmodule

// File: rtl/rop_logic_unit.sv
module rop_logic_unit
  import rop_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [4:0]    regIdx,
  input  logic [DW-1:0] regData,
  input  logic          cycValid,
  input  logic [1:0]    cycKind,
  input  logic          cycBank,
  input  logic [DW-1:0] memData,
  output logic [DW-1:0] resData,
  output logic          resValid
);
  ropStrobe_t    strobe;
  logic [FW-1:0] funcWord;

  rop_ctrl #(.FW(FW)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regData(regData[FW-1:0]), .cycValid(cycValid), .cycKind(cycKind),
    .cycBank(cycBank), .funcWord(funcWord), .strobe(strobe)
  );

  rop_datapath #(.DW(DW), .FW(FW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .funcWord(funcWord),
    .hostData(regData), .memData(memData), .resData(resData), .resValid(resValid)
  );

  // R9: first-source and second-source cycles never produce a strobe
  a_r9_src_cycle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycKind != KIND_DEST) |=> !resValid);
endmodule

// File: tb/rop_logic_unit_tb.sv
module rop_logic_unit_tb_top;
  logic clk = 0, rstN = 0, regWrEn = 0, cycValid = 0, cycBank = 0;
  logic [4:0] regIdx = '0;
  logic [15:0] regData = '0, memData = '0, resData;
  logic [1:0] cycKind = '0;
  logic resValid;
  int checks = 0, errors = 0;

  logic [6:0]  shFunc = '0;
  logic [15:0] shSrc = '0, shM1 = '0, shM2 = '0, shFg = '0, shBg = '0, shRes = '0;
  logic [4:0]  shCw [8];

  always #5 clk = ~clk;

  rop_logic_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regData(regData),
    .cycValid(cycValid), .cycKind(cycKind), .cycBank(cycBank), .memData(memData),
    .resData(resData), .resValid(resValid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] d);
    logic [15:0] s, m, r;
    s = shFunc[6] ? shSrc : ~shSrc;
    m = (shFunc[4] ? ~shM1 : shM1) & (shFunc[5] ? ~shM2 : shM2);
    for (int i = 0; i < 16; i++) r[i] = m[i] ? shFunc[{d[i], s[i]}] : d[i];
    return r;
  endfunction

  task automatic wr(input logic [4:0] idx, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1; regIdx = idx; regData = val;
    @(posedge clk); #1;
    regWrEn = 0;
    case (idx)
      5'h04: shFunc = val[6:0];
      5'h08: begin shM1 = val; shM2 = val; end
      5'h09: shM2 = val;
      5'h0A: shSrc = val;
      5'h0E: shBg = val;
      5'h0F: shFg = val;
      5'h10, 5'h11, 5'h12, 5'h14, 5'h15, 5'h16: shCw[idx[2:0]] = val[4:0];
      default: ;
    endcase
  endtask

  task automatic cyc(input int bank, input int kind, input logic [15:0] mem, input string req);
    logic [4:0] w;
    logic expV;
    logic [15:0] expD, idata;
    w = shCw[bank * 4 + kind];
    expV = (kind == 2) && w[4];
    expD = expV ? model(mem) : shRes;
    @(negedge clk);
    cycValid = 1; cycKind = kind[1:0]; cycBank = bank[0]; memData = mem;
    @(posedge clk); #1;
    cycValid = 0;
    chk({req, " valid"}, {15'd0, resValid}, {15'd0, expV});
    chk({req, " data"}, resData, expD);
    shRes = expD;
    idata = bank[0] ? shBg : shFg;
    if (w[1:0] == 2'b01) shSrc = mem; else if (w[3:2] == 2'b01) shSrc = idata;
    if (w[1:0] == 2'b10) shM1 = mem; else if (w[3:2] == 2'b10) shM1 = idata;
    if (w[1] == 1'b1) shM2 = mem; else if (w[3] == 1'b1) shM2 = idata;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {15'd0, resValid}, 16'd0);
    chk("R1 reset data", resData, 16'd0);
  endtask

  task automatic t_funcs;
    wr(5'h12, 16'h0010);
    wr(5'h08, 16'hFFFF);
    wr(5'h0A, 16'hF0F0);
    for (int c = 0; c < 16; c++) begin
      wr(5'h04, 16'h0040 | 16'(c));
      cyc(0, 2, 16'hFF00, "R2 function code");
    end
  endtask

  task automatic t_masks;
    wr(5'h08, 16'h0FF0);
    wr(5'h09, 16'h3C3C);
    wr(5'h04, 16'h004F); cyc(0, 2, 16'h0000, "R3 masks plain");
    wr(5'h04, 16'h005F); cyc(0, 2, 16'h0000, "R3 mask1 inverted");
    wr(5'h04, 16'h006F); cyc(0, 2, 16'h0000, "R3 mask2 inverted");
    wr(5'h04, 16'h0070); cyc(0, 2, 16'hFFFF, "R3 both inverted zero fn");
  endtask

  task automatic t_srcinv;
    wr(5'h08, 16'hFFFF);
    wr(5'h0A, 16'h1234);
    wr(5'h04, 16'h000A); cyc(0, 2, 16'h5555, "R4 source inverted");
    wr(5'h04, 16'h004A); cyc(0, 2, 16'h5555, "R4 source direct");
  endtask

  task automatic t_mask2only;
    wr(5'h04, 16'h004F);
    wr(5'h08, 16'hFFFF);
    wr(5'h09, 16'h00FF); cyc(0, 2, 16'h0000, "R5 mask2 write only");
    wr(5'h08, 16'hF000); cyc(0, 2, 16'h0000, "R5 mask1 copies");
    wr(5'h03, 16'h0000); cyc(0, 2, 16'h0000, "R5 unmapped index");
  endtask

  task automatic t_ext;
    wr(5'h08, 16'hFFFF);
    wr(5'h10, 16'h0001);
    cyc(0, 0, 16'hBEEF, "R7 src load no output");
    wr(5'h04, 16'h004A); cyc(0, 2, 16'h0000, "R7 ext source");
    wr(5'h16, 16'h0010);
    wr(5'h15, 16'h0002);
    cyc(1, 1, 16'h0F0F, "R6 bank1 second source");
    wr(5'h04, 16'h004F); cyc(1, 2, 16'h0000, "R7 ext both masks");
    wr(5'h14, 16'h0003);
    cyc(1, 0, 16'h0FF0, "R6 bank1 first source");
    cyc(1, 2, 16'h0000, "R7 ext mask2 only");
  endtask

  task automatic t_int;
    wr(5'h08, 16'hFFFF);
    wr(5'h0F, 16'hAAAA);
    wr(5'h0E, 16'h5555);
    wr(5'h04, 16'h004A);
    wr(5'h11, 16'h0004);
    cyc(0, 1, 16'h1234, "R8 int fg load");
    cyc(0, 2, 16'h0000, "R8 foreground source");
    wr(5'h15, 16'h0004);
    cyc(1, 1, 16'h1234, "R8 int bg load");
    cyc(1, 2, 16'h0000, "R8 background source");
  endtask

  task automatic t_prio;
    wr(5'h10, 16'h0005);
    cyc(0, 0, 16'h1111, "R10 ext and int");
    cyc(0, 2, 16'h0000, "R10 ext wins");
  endtask

  task automatic t_noout;
    wr(5'h12, 16'h0000);
    cyc(0, 2, 16'h7777, "R9 dest no outEn");
    wr(5'h12, 16'h0010);
    cyc(0, 2, 16'h8888, "R9 dest outEn");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) shCw[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rstN = 1;
    cyc(0, 2, 16'h1234, "R9 reset ctrl no output");
    t_funcs;
    t_masks;
    t_srcinv;
    t_mask2only;
    t_ext;
    t_int;
    t_prio;
    t_noout;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule